// File: doc/BRIEF.md
# Power-Up Frequency Strap Capture and Power-Down Qualifier

This block sits beside a clock synthesizer's control logic. At power-up it waits for the platform to signal that the processor supply is good. A shared input pin carries that signal as an active-low level. When the block first sees that level, it captures three frequency-select straps and one table-select strap. It then decodes them into a small CPU frequency code and a reserved flag. From that moment the captured values are frozen, and any later movement on the straps is ignored.

After the capture, the same pin changes meaning and becomes an active-high power-down request. The block passes the pin through a synchronizer on the reference clock. It raises its power-down output only after it has seen the synchronized level high on consecutive rising edges. The block does not generate any clock; it only produces codes and a request level for the rest of the clock chip.

Frequency code encoding used throughout: 0 = none or reserved, 1 = 100 MHz, 2 = 133 MHz, 3 = 200 MHz, 4 = 266 MHz. The straps are numbered as `fs_strap[2]` = C, `fs_strap[1]` = B and `fs_strap[0]` = A.

Top module: `fsel_strap_ctrl`

## Requirements
- R1: The pin passes through a two-flop synchronizer. When the pin is low at a rising edge while the block is waiting, the capture happens at the second rising edge after that one, using the strap values present at that edge. So with the pin driven low before edge k, `strap_rb` shows the captured value after edge k+2 and not before.
- R2: The capture fires only once per reset. After it, changes on the straps, on the table-select input, or further low or high phases of the pin leave `strap_rb`, `freq_code` and `freq_rsvd` unchanged.
- R3: `strap_rb[3:0]` holds the captured table-select bit in bit 3, C in bit 2, B in bit 1 and A in bit 0.
- R4: With a captured table-select of 0, the code decodes from {C,B,A} as follows: 101 gives 1, 001 gives 2, 010 gives 3, 000 gives 4, and `freq_rsvd` is 0 for these.
- R5: With a captured table-select of 1, only {B,A} decode: 00 gives 1, 01 gives 2, 10 gives 3. C has no effect on the result.
- R6: Any captured combination not listed in R4 or R5, including 111 with table-select 0 and BA = 11 with table-select 1, gives `freq_rsvd` = 1 and `freq_code` = 0.
- R7: After the capture, `pd_req` rises after the edge at which the synchronized pin level has been high on two consecutive rising edges. It falls after the first edge at which the synchronized level is low. A high level seen on a single edge never raises it.
- R8: While the capture has not fired, including directly after `rst_n` is low, `pd_req`, `strap_rb`, `freq_code` and `freq_rsvd` are all 0. A reset returns the block to waiting for the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd_pd_in | input | 1 | Shared pin: power-good strobe (active low) before capture, power-down (active high) after |
| fs_strap | input | 3 | Frequency-select straps {C,B,A} |
| tbl_strap | input | 1 | Table-select strap |
| strap_rb | output | 4 | Captured straps for register readback {table, C, B, A} |
| freq_code | output | 3 | Decoded CPU frequency code |
| freq_rsvd | output | 1 | Captured combination is reserved |
| pd_req | output | 1 | Qualified power-down request |

## Verification
The bench walks all sixteen strap and table combinations, each after its own reset. A decoder that ignored the table bit, or that let C leak into the two-bit table, would then return a wrong code on at least one of them. It probes the capture edge exactly: a design with a missing synchronizer stage, or one that samples the straps late, shows a readback one cycle early or holds the value changed after the strobe. Once the capture has happened, it moves the straps and pulses the pin for a single cycle. A latch that re-arms would pick up the new straps, and a power-down path without the two-sample filter would raise its request on the lone high sample. It also releases and reasserts the request to confirm that it drops on the first low sample.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
   localparam int FS_W   = 3;
   localparam int RB_W   = FS_W + 1;
   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      FREQ_NONE = 3'd0,
      FREQ_100  = 3'd1,
      FREQ_133  = 3'd2,
      FREQ_200  = 3'd3,
      FREQ_266  = 3'd4
   } freq_e;

   // strap word: [3]=table, [2]=C, [1]=B, [0]=A
   function automatic freq_e decode_strap(input logic [RB_W-1:0] s);
      freq_e f;
      f = FREQ_NONE;
      if (!s[RB_W-1]) begin
         case (s[FS_W-1:0])
            3'b101:  f = FREQ_100;
            3'b001:  f = FREQ_133;
            3'b010:  f = FREQ_200;
            3'b000:  f = FREQ_266;
            default: f = FREQ_NONE;
         endcase
      end else begin
         case (s[1:0])
            2'b00:   f = FREQ_100;
            2'b01:   f = FREQ_133;
            2'b10:   f = FREQ_200;
            default: f = FREQ_NONE;
         endcase
      end
      return f;
   endfunction
endpackage

// File: rtl/fsel_sync.sv
module fsel_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fsel_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_in};
   end

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sync_lvl,
   input  logic [W-1:0] straps,
   output logic         armed,
   output logic [W-1:0] captured
);
   generate
      if (W < 2) begin : g_bad_width
         $error("fsel_strap_latch: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         captured <= '0;
      end else if (!armed && !sync_lvl) begin
         armed    <= 1'b1;
         captured <= straps;
      end
   end

   AST_ONE_SHOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed); // R2
   AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> $stable(captured)); // R2
   AST_FIRES_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> !$past(sync_lvl)); // R1
endmodule

// File: rtl/fsel_pd_filter.sv
module fsel_pd_filter #(
   parameter int CONFIRM = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic sync_lvl,
   output logic pd_req
);
   generate
      if (CONFIRM < 1) begin : g_bad_confirm
         $error("fsel_pd_filter: CONFIRM must be at least 1");
      end
   endgenerate

   localparam int CW = $clog2(CONFIRM) + 1;
   localparam logic [CW-1:0] LAST = CW'(CONFIRM - 1);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         pd_req  <= 1'b0;
      end else if (!armed || !sync_lvl) begin
         run_cnt <= '0;
         pd_req  <= 1'b0;
      end else if (run_cnt < LAST) begin
         run_cnt <= run_cnt + 1'b1;
      end else begin
         pd_req  <= 1'b1;
      end
   end

   AST_PD_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_req) |-> $past(sync_lvl)); // R7
   AST_PD_DROPS_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_req && !sync_lvl) |=> !pd_req); // R7
   AST_PD_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !pd_req); // R8
endmodule

// File: rtl/fsel_decode.sv
module fsel_decode
   import fsel_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [RB_W-1:0]   strap,
   output logic [CODE_W-1:0] code,
   output logic              rsvd
);
   freq_e dec;
   logic  rsvd_c;

   always_comb begin
      dec    = valid ? decode_strap(strap) : FREQ_NONE;
      rsvd_c = valid && (dec == FREQ_NONE);
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               code <= '0;
               rsvd <= 1'b0;
            end else begin
               code <= dec;
               rsvd <= rsvd_c;
            end
         end
      end else begin : g_comb
         assign code = dec;
         assign rsvd = rsvd_c;
      end
   endgenerate

   AST_RSVD_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      rsvd |-> (code == '0)); // R6
   AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      code <= CODE_W'(FREQ_266)); // R4
endmodule

// File: rtl/fsel_strap_ctrl.sv
module fsel_strap_ctrl
   import fsel_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PD_CONFIRM  = 2,
   parameter bit DECODE_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwrgd_pd_in,
   input  logic [FS_W-1:0]   fs_strap,
   input  logic              tbl_strap,
   output logic [RB_W-1:0]   strap_rb,
   output logic [CODE_W-1:0] freq_code,
   output logic              freq_rsvd,
   output logic              pd_req
);
   logic pin_sync;
   logic armed;

   fsel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pwrgd_pd_in),
      .q_out (pin_sync)
   );

   fsel_strap_latch #(.W(RB_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_lvl (pin_sync),
      .straps   ({tbl_strap, fs_strap}),
      .armed    (armed),
      .captured (strap_rb)
   );

   fsel_decode #(.OUT_REG(DECODE_REG)) u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (armed),
      .strap (strap_rb),
      .code  (freq_code),
      .rsvd  (freq_rsvd)
   );

   fsel_pd_filter #(.CONFIRM(PD_CONFIRM)) u_pd (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (armed),
      .sync_lvl (pin_sync),
      .pd_req   (pd_req)
   );

   AST_IDLE_READBACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (strap_rb == '0)); // R8
endmodule

// File: tb/fsel_strap_ctrl_test.sv
module fsel_strap_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin = 1'b1;
   logic [2:0] fs = 3'b000;
   logic       tbl = 1'b0;
   logic [3:0] strap_rb;
   logic [2:0] freq_code;
   logic       freq_rsvd;
   logic       pd_req;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fsel_strap_ctrl uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .pwrgd_pd_in (pin),
      .fs_strap    (fs),
      .tbl_strap   (tbl),
      .strap_rb    (strap_rb),
      .freq_code   (freq_code),
      .freq_rsvd   (freq_rsvd),
      .pd_req      (pd_req)
   );

   // expected code from the requirement tables (R4 R5 R6)
   function automatic int exp_code(input logic [3:0] s);
      if (!s[3]) begin
         if (s[2:0] == 3'b101) return 1;
         if (s[2:0] == 3'b001) return 2;
         if (s[2:0] == 3'b010) return 3;
         if (s[2:0] == 3'b000) return 4;
         return 0;
      end
      if (s[1:0] == 2'b00) return 1;
      if (s[1:0] == 2'b01) return 2;
      if (s[1:0] == 2'b10) return 3;
      return 0;
   endfunction

   // behavioural reference: pin history queue, capture flag, high-run count
   logic       hist[$];
   bit         m_cap_done = 1'b0;
   logic [3:0] m_cap = 4'h0;
   int         m_run = 0;

   initial begin
      hist.push_back(1'b1);
      hist.push_back(1'b1);
   end

   always @(posedge clk) begin
      logic seen;
      bit   was_done;
      if (!rst_n) begin
         hist.delete();
         hist.push_back(1'b1);
         hist.push_back(1'b1);
         m_cap_done = 1'b0;
         m_cap      = 4'h0;
         m_run      = 0;
      end else begin
         seen     = hist[0];
         was_done = m_cap_done;
         if (was_done && seen) m_run = (m_run < 2) ? m_run + 1 : 2;
         else                  m_run = 0;
         if (!was_done && !seen) begin
            m_cap_done = 1'b1;
            m_cap      = {tbl, fs};
         end
         void'(hist.pop_front());
         hist.push_back(pin);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // compare against the reference on every clock
   always @(negedge clk) begin
      int ec;
      if (!done) begin
         ec = m_cap_done ? exp_code(m_cap) : 0;
         check("R3 strap_rb", int'(strap_rb), int'(m_cap));
         check("R4 R5 freq_code", int'(freq_code), ec);
         check("R6 freq_rsvd", int'(freq_rsvd), (m_cap_done && ec == 0) ? 1 : 0);
         check("R7 pd_req", int'(pd_req), (m_run >= 2) ? 1 : 0);
      end
   end

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic run_case(input logic t, input logic [2:0] f);
      logic [3:0] want;
      want = {t, f};
      @(negedge clk);
      rst_n = 1'b0; pin = 1'b1; tbl = t; fs = f;
      wait_neg(2);
      check("R8 reset readback", int'(strap_rb), 0);
      rst_n = 1'b1;
      wait_neg(3);
      check("R8 idle pd", int'(pd_req), 0);
      check("R8 idle code", int'(freq_code), 0);
      pin = 1'b0;
      wait_neg(2);
      check("R1 not yet captured", int'(strap_rb), 0);
      wait_neg(1);
      check("R1 captured", int'(strap_rb), int'(want));
      check("R3 bit order", int'(strap_rb[3]), int'(t));
      if (t) check("R5 table one", int'(freq_code), exp_code(want));
      else   check("R4 table zero", int'(freq_code), exp_code(want));
      check("R6 reserved flag", int'(freq_rsvd), (exp_code(want) == 0) ? 1 : 0);
      // disturb straps and strobe once more
      tbl = ~t; fs = ~f;
      pin = 1'b1;
      wait_neg(1);
      pin = 1'b0;
      wait_neg(5);
      check("R2 readback frozen", int'(strap_rb), int'(want));
      check("R2 code frozen", int'(freq_code), exp_code(want));
      check("R7 single high ignored", int'(pd_req), 0);
      // sustained power-down request
      pin = 1'b1;
      wait_neg(3);
      check("R7 not yet qualified", int'(pd_req), 0);
      wait_neg(1);
      check("R7 qualified", int'(pd_req), 1);
      check("R2 pd leaves readback", int'(strap_rb), int'(want));
      pin = 1'b0;
      wait_neg(2);
      check("R7 still held", int'(pd_req), 1);
      wait_neg(1);
      check("R7 released", int'(pd_req), 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      wait_neg(2);
      for (int k = 0; k < 16; k++) begin
         run_case(k[3], k[2:0]);
      end
      // table one: C must not change the result (R5)
      run_case(1'b1, 3'b110);
      check("R5 C ignored", int'(freq_code), 3);
      wait_neg(2);
      finish_run();
   end

   initial begin
      #400000;
      miscompares++;
      $display("FAIL watchdog expired at %0t", $time);
      finish_run();
   end
endmodule